// File: doc/BRIEF.md
# Four-Phase Fetch/Execute Sequencer

This block paces a small accumulator-style core. It divides the input clock into four fixed phases that repeat, Q1 to Q4, and one instruction cycle spans one round of these phases. Each phase marks a fixed step of the cycle. The program counter moves in Q1. Operands are read in Q2. Results are written back in Q4. The next program word is captured at the close of Q4.

Fetch and execute overlap. While the word at address N executes, the word at N+1 is being fetched. A straight-line instruction therefore retires once per instruction cycle. The execute side can report a taken jump or call during Q4, together with its target. The sequencer then discards the word it has already fetched, loads the target, and runs one empty cycle, so a taken branch costs two instruction cycles.

The block owns the program counter, the fetch latch, the instruction register and the data-memory strobes. Decode, the ALU and the register file sit outside it.

Top module: `qseq_top`

## Requirements
- R1: `phaseEn` is one-hot at all times. Bit 0 is Q1, bit 1 is Q2, bit 2 is Q3 and bit 3 is Q4. The phases advance one per clock in the order Q1, Q2, Q3, Q4 and then return to Q1.
- R2: While `rst` is high at a clock edge, the block goes to Q1, `progAddr` becomes 0, `irValid` becomes 0, and all strobes are low. The first instruction cycle after reset fetches address 0 and executes nothing.
- R3: `progAddr` advances by one at the end of Q1 in every instruction cycle except the first one after reset. It then holds from Q2 until the next Q1 ends.
- R4: The word on `progData` is captured at the end of Q4. It appears on `instrReg` from Q2 of the next instruction cycle, with `irValid` high.
- R5: In a cycle that executes, `dataRdStb` is high only in Q2 and `dataWrStb` is high only in Q4.
- R6: A `branchTaken` seen in Q4 of a cycle that executes loads `branchTarget` as the next `progAddr`, in place of the incremented value. The word already fetched is discarded.
- R7: The cycle after a taken branch is a bubble. In that cycle `irValid`, `executing`, `dataRdStb` and `dataWrStb` stay low, and a `branchTaken` raised during it has no effect on `progAddr`.
- R8: `clkOut` runs at the clock rate divided by four. It is high in Q1 and Q2 and low in Q3 and Q4.
- R9: The program counter is 11 bits wide and steps from 0x7FF to 0x000.
- R10: A `branchTaken` raised in Q1, Q2 or Q3 and dropped before Q4 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock, four per instruction cycle |
| rst | input | 1 | Synchronous reset, active high |
| branchTaken | input | 1 | Execute side requests a jump or call (used in Q4) |
| branchTarget | input | 11 | Jump or call destination |
| progData | input | 14 | Program memory word at `progAddr` |
| progAddr | output | 11 | Program counter, address of the word being fetched |
| phaseEn | output | 4 | One-hot phase enables, bit 0 is Q1 |
| clkOut | output | 1 | Instruction-cycle clock, high in Q1 and Q2 |
| instrReg | output | 14 | Instruction register |
| irValid | output | 1 | Instruction register holds a real instruction |
| executing | output | 1 | Instruction executing (Q2 to Q4 of a cycle that is not a bubble) |
| dataRdStb | output | 1 | Operand read strobe |
| dataWrStb | output | 1 | Destination write strobe |

## Verification
A phase counter that slips shows up on `phaseEn` and `clkOut` within one clock. It also moves the strobes away from Q2 and Q4 within the same instruction cycle.

A program counter or fetch latch that is off by one is visible on `progAddr` in the Q2 after the fault. It reaches `instrReg` one instruction cycle later.

Bubble tracking that goes wrong appears as a strobe or `irValid` during the cycle after a branch. It can also appear as a spurious jump taken from a bubble. Both are visible within the two cycles that the branch occupies.

The stimulus crosses the 0x7FF wrap and includes branches issued back to back. It also raises a branch request during a bubble, raises one that is dropped before Q4, and applies a reset in the middle of a cycle.

// File: rtl/qseq_pkg.sv
package qseq_pkg;

  localparam int PHASE_CNT = 4;

  typedef enum logic [1:0] {
    PH_Q1 = 2'd0,
    PH_Q2 = 2'd1,
    PH_Q3 = 2'd2,
    PH_Q4 = 2'd3
  } phase_e;

  // per-edge enables from control to datapath; each acts on the clock edge
  // that closes the current phase
  typedef struct packed {
    logic latchFetch;  // capture program word into fetch latch
    logic loadIr;      // move fetch latch into instruction register
    logic stepPc;      // pc <= pc + 1
    logic jumpPc;      // pc <= stored branch target
    logic grabTarget;  // store branch target
  } seqStrobes_t;

endpackage

// File: rtl/qseq_ctrl.sv
module qseq_ctrl
  import qseq_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        branchTaken,
  output logic [PHASE_CNT-1:0] phaseEn,
  output logic        clkOut,
  output logic        irValid,
  output logic        executing,
  output logic        dataRdStb,
  output logic        dataWrStb,
  output seqStrobes_t strobes
);

  phase_e phase;
  logic   firstCyc;    // first instruction cycle after reset: no pc step
  logic   fetchValid;  // fetch latch holds a word worth executing
  logic   irValidQ;
  logic   jumpPend;    // branch accepted, applied at next Q1
  logic   takeBr;

  assign takeBr = (phase == PH_Q4) && irValidQ && branchTaken;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase      <= PH_Q1;
      firstCyc   <= 1'b1;
      fetchValid <= 1'b0;
      irValidQ   <= 1'b0;
      jumpPend   <= 1'b0;
    end else begin
      phase <= phase_e'(phase + 2'd1);
      case (phase)
        PH_Q1: begin
          irValidQ <= fetchValid;
          firstCyc <= 1'b0;
          jumpPend <= 1'b0;
        end
        PH_Q4: begin
          fetchValid <= !takeBr;
          jumpPend   <= takeBr;
        end
        default: ;
      endcase
    end
  end

  genvar gi;
  generate
    for (gi = 0; gi < PHASE_CNT; gi++) begin : g_phase
      assign phaseEn[gi] = (phase == phase_e'(gi));
    end
  endgenerate

  always_comb begin
    strobes.latchFetch = (phase == PH_Q4);
    strobes.loadIr     = (phase == PH_Q1);
    strobes.stepPc     = (phase == PH_Q1) && !firstCyc && !jumpPend;
    strobes.jumpPc     = (phase == PH_Q1) && jumpPend;
    strobes.grabTarget = takeBr;
  end

  assign clkOut    = (phase == PH_Q1) || (phase == PH_Q2);
  assign irValid   = irValidQ;
  assign executing = irValidQ && (phase != PH_Q1);
  assign dataRdStb = irValidQ && (phase == PH_Q2);
  assign dataWrStb = irValidQ && (phase == PH_Q4);

  AST_PHASE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $countones(phaseEn) == 1); // R1
  AST_PHASE_WRAP: assert property (@(posedge clk) disable iff (rst)
    phaseEn[3] |=> phaseEn[0]); // R1
  AST_STROBE_SPLIT: assert property (@(posedge clk) disable iff (rst)
    !(dataRdStb && dataWrStb)); // R5
  AST_RD_BEFORE_WR: assert property (@(posedge clk) disable iff (rst)
    dataWrStb |-> $past(dataRdStb, 2)); // R5
  AST_BRANCH_BUBBLE: assert property (@(posedge clk) disable iff (rst)
    takeBr |=> ##1 !irValidQ); // R7
  AST_CLKOUT_FALL: assert property (@(posedge clk) disable iff (rst)
    $fell(clkOut) |-> phaseEn[2]); // R8

endmodule

// File: rtl/qseq_dpath.sv
module qseq_dpath
  import qseq_pkg::*;
#(
  parameter int PC_W    = 11,
  parameter int INSTR_W = 14
) (
  input  logic               clk,
  input  logic               rst,
  input  seqStrobes_t        strobes,
  input  logic [PC_W-1:0]    branchTarget,
  input  logic [INSTR_W-1:0] progData,
  output logic [PC_W-1:0]    pc,
  output logic [INSTR_W-1:0] instrReg
);

  localparam logic [PC_W-1:0] PC_ONE = PC_W'(1);

  logic [INSTR_W-1:0] fetchLatch;
  logic [PC_W-1:0]    targetReg;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc         <= '0;
      fetchLatch <= '0;
      instrReg   <= '0;
      targetReg  <= '0;
    end else begin
      if (strobes.grabTarget) targetReg  <= branchTarget;
      if (strobes.latchFetch) fetchLatch <= progData;
      if (strobes.loadIr)     instrReg   <= fetchLatch;
      if (strobes.jumpPc)      pc <= targetReg;
      else if (strobes.stepPc) pc <= pc + PC_ONE;
    end
  end

  AST_PC_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(strobes.stepPc || strobes.jumpPc) |=> $stable(pc)); // R3
  AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
    strobes.stepPc |=> pc == $past(pc) + PC_ONE); // R9
  AST_JUMP_LOAD: assert property (@(posedge clk) disable iff (rst)
    strobes.grabTarget |=> strobes.jumpPc); // R6
  AST_STEP_JUMP_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(strobes.stepPc && strobes.jumpPc)); // R6

endmodule

// File: rtl/qseq_top.sv
module qseq_top
  import qseq_pkg::*;
#(
  parameter int PC_W    = 11,
  parameter int INSTR_W = 14
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               branchTaken,
  input  logic [PC_W-1:0]    branchTarget,
  input  logic [INSTR_W-1:0] progData,
  output logic [PC_W-1:0]    progAddr,
  output logic [3:0]         phaseEn,
  output logic               clkOut,
  output logic [INSTR_W-1:0] instrReg,
  output logic               irValid,
  output logic               executing,
  output logic               dataRdStb,
  output logic               dataWrStb
);

  seqStrobes_t strobes;

  qseq_ctrl u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .branchTaken (branchTaken),
    .phaseEn     (phaseEn),
    .clkOut      (clkOut),
    .irValid     (irValid),
    .executing   (executing),
    .dataRdStb   (dataRdStb),
    .dataWrStb   (dataWrStb),
    .strobes     (strobes)
  );

  qseq_dpath #(.PC_W(PC_W), .INSTR_W(INSTR_W)) u_dpath (
    .clk          (clk),
    .rst          (rst),
    .strobes      (strobes),
    .branchTarget (branchTarget),
    .progData     (progData),
    .pc           (progAddr),
    .instrReg     (instrReg)
  );

  AST_RESET_ADDR: assert property (@(posedge clk)
    $past(rst) |-> (progAddr == '0) && !irValid && phaseEn[0]); // R2

endmodule

// File: tb/tb_qseq_top.sv
module tb_qseq_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        branchTaken = 1'b0;
  logic [10:0] branchTarget = '0;
  logic [13:0] progData;
  logic [10:0] progAddr;
  logic [3:0]  phaseEn;
  logic        clkOut, irValid, executing, dataRdStb, dataWrStb;
  logic [13:0] instrReg;

  int checkCnt = 0;
  int failCnt  = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  function automatic logic [13:0] memWord(input logic [10:0] a);
    return {3'b101, a};
  endfunction

  assign progData = memWord(progAddr);

  qseq_top dut (
    .clk(clk), .rst(rst), .branchTaken(branchTaken), .branchTarget(branchTarget),
    .progData(progData), .progAddr(progAddr), .phaseEn(phaseEn), .clkOut(clkOut),
    .instrReg(instrReg), .irValid(irValid), .executing(executing),
    .dataRdStb(dataRdStb), .dataWrStb(dataWrStb)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // one instruction cycle, entered at the negedge inside Q1
  task automatic runCycle(input logic br, input logic [10:0] tgt, input logic dropAtQ4,
                          input logic [10:0] expAddr, input logic expValid,
                          input logic [10:0] expIrAddr);
    for (int p = 0; p < 4; p++) begin
      if (p == 0) begin branchTaken = br; branchTarget = tgt; end
      if (p == 3 && dropAtQ4) branchTaken = 1'b0;
      #1;
      chk(phaseEn == 4'(1 << p), "R1", "phaseEn", 32'(phaseEn), 32'(1 << p));
      chk(clkOut == (p < 2), "R8", "clkOut", 32'(clkOut), 32'(p < 2));
      chk(dataRdStb == (expValid && p == 1), "R5", "dataRdStb", 32'(dataRdStb), 32'(expValid && p == 1));
      chk(dataWrStb == (expValid && p == 3), "R5", "dataWrStb", 32'(dataWrStb), 32'(expValid && p == 3));
      chk(executing == (expValid && p != 0), "R7", "executing", 32'(executing), 32'(expValid && p != 0));
      if (p != 0) begin
        chk(progAddr == expAddr, "R3", "progAddr", 32'(progAddr), 32'(expAddr));
        chk(irValid == expValid, "R4", "irValid", 32'(irValid), 32'(expValid));
        if (expValid)
          chk(instrReg == memWord(expIrAddr), "R4", "instrReg", 32'(instrReg), 32'(memWord(expIrAddr)));
      end
      @(negedge clk);
    end
  endtask

  // {branch, target, expAddr, expValid, expIrAddr}
  localparam int NVEC = 15;
  localparam logic [34:0] VEC [NVEC] = '{
    {1'b0, 11'h000, 11'h000, 1'b0, 11'h000},  // R2 first cycle fetches 0, executes nothing
    {1'b0, 11'h000, 11'h001, 1'b1, 11'h000},
    {1'b0, 11'h000, 11'h002, 1'b1, 11'h001},
    {1'b1, 11'h100, 11'h003, 1'b1, 11'h002},  // R6 jump to 0x100
    {1'b1, 11'h055, 11'h100, 1'b0, 11'h000},  // R7 bubble, its branch ignored
    {1'b0, 11'h000, 11'h101, 1'b1, 11'h100},
    {1'b1, 11'h7FE, 11'h102, 1'b1, 11'h101},  // R6 jump near top
    {1'b0, 11'h000, 11'h7FE, 1'b0, 11'h000},  // R7
    {1'b0, 11'h000, 11'h7FF, 1'b1, 11'h7FE},
    {1'b0, 11'h000, 11'h000, 1'b1, 11'h7FF},  // R9 wrap to zero
    {1'b1, 11'h020, 11'h001, 1'b1, 11'h000},
    {1'b0, 11'h000, 11'h020, 1'b0, 11'h000},
    {1'b1, 11'h040, 11'h021, 1'b1, 11'h020},  // R6 branch right after bubble
    {1'b0, 11'h000, 11'h040, 1'b0, 11'h000},
    {1'b0, 11'h000, 11'h041, 1'b1, 11'h040}
  };

  task automatic checkReset();
    #1;
    chk(phaseEn == 4'b0001, "R2", "reset phaseEn", 32'(phaseEn), 32'h1);
    chk(progAddr == 11'h000, "R2", "reset progAddr", 32'(progAddr), 32'h0);
    chk(irValid == 1'b0, "R2", "reset irValid", 32'(irValid), 32'h0);
    chk(!dataRdStb && !dataWrStb && !executing, "R2", "reset strobes",
        32'({dataRdStb, dataWrStb, executing}), 32'h0);
  endtask

  initial begin
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checkReset();
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < NVEC; i++)
      runCycle(VEC[i][34], VEC[i][33:23], 1'b0, VEC[i][22:12], VEC[i][11], VEC[i][10:0]);
    // R10: request held in Q1..Q3, dropped before Q4
    runCycle(1'b1, 11'h300, 1'b1, 11'h042, 1'b1, 11'h041);
    runCycle(1'b0, 11'h000, 1'b0, 11'h043, 1'b1, 11'h042);  // R10 no jump taken
    // R2: reset in the middle of a cycle
    @(negedge clk);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    checkReset();
    @(negedge clk);
    rst = 1'b0;
    runCycle(1'b0, 11'h000, 1'b0, 11'h000, 1'b0, 11'h000);  // R2
    runCycle(1'b0, 11'h000, 1'b0, 11'h001, 1'b1, 11'h000);
    runCycle(1'b0, 11'h000, 1'b0, 11'h002, 1'b1, 11'h001);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end

  initial begin
    #(8 * 5000);
    if (!done) begin
      checkCnt++;
      failCnt++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
      $finish;
    end
  end

endmodule